// File: doc/BRIEF.md
# GF(2^233) Polynomial-Basis Field Multiplier

This block multiplies two elements of the binary field GF(2^233). Each element is a 233-bit vector whose bit k is the coefficient of x^k in a polynomial of degree at most 232. The block forms the full carry-less product in a dedicated tree for each of the 465 product coefficients. It then folds that product back into 233 bits modulo the trinomial x^233 + x^74 + 1.

A client raises `in_start` for one cycle with both operands. Three rising edges later `out_valid` is high for one cycle and `out_result` carries the reduced product. A new operand pair may be presented on every cycle, so results stream out back to back with the same fixed delay.

Between results the output word holds its last value. Operands presented while `in_start` is low are never used.

Top module: `gf233_mul`

## Requirements
- R1: For any operands A and B, `out_result` equals A·B reduced modulo x^233 + x^74 + 1, where bit k of each vector is the coefficient of x^k.
- R2: `out_valid` rises exactly three rising clock edges after the edge that samples `in_start` high, counting that edge as the first, and stays high for one cycle per accepted pair.
- R3: Pairs presented on consecutive cycles are all accepted, and their results appear on consecutive cycles in the same order.
- R4: If either operand is zero, the result is zero.
- R5: Multiplying by the element 1 (only bit 0 set) returns the other operand unchanged.
- R6: Product terms of degree 233 and above wrap to degrees k−233 and k−159, and the wrap is repeated until the degree is below 233. For example, x^232·x gives bits 74 and 0, and x^232·x^232 gives bits 231, 146 and 72.
- R7: While no result is emerging, `out_valid` is low and `out_result` keeps its previous value.
- R8: While `rst_n` is low, `out_valid` is low, and any operation in flight when reset is asserted produces no result.
- R9: Operand values presented while `in_start` is low have no effect on `out_valid` or `out_result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| in_start | input | 1 | Accept the operand pair on this edge |
| in_a | input | 233 | First operand, bit k = coefficient of x^k |
| in_b | input | 233 | Second operand, bit k = coefficient of x^k |
| out_valid | output | 1 | `out_result` holds a new product this cycle |
| out_result | output | 233 | Reduced product, bit k = coefficient of x^k |

## Verification
The bench instantiates the multiplier with its default width of 233 and wrap tap of 74, which are the values the field needs. At these values the top coefficient x^464 folds to degree 305 and must fold a second time. Squaring x^232 therefore exercises both passes of the reduction network and shows whether the second fold is missing. Random operand streams are compared against a bit-serial shift-and-add model built from the same two parameters, so every tree and every fold path is covered.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
  // Field degree and middle tap of the reduction trinomial x^W + x^T + 1
  localparam int unsigned GF_WIDTH = 233;
  localparam int unsigned GF_TAP   = 74;
  // Pipeline depth from operand capture to result register
  localparam int unsigned GF_LATENCY = 3;
endpackage

// File: rtl/gf2m_clmul.sv
// Carry-less product: one parity tree per output coefficient.
module gf2m_clmul #(
  parameter int unsigned N = 233
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-2:0] prod
);
  localparam int unsigned PW = 2*N - 1;
  localparam int unsigned EW = 3*N - 2;

  logic [N-1:0]  b_rev;
  logic [EW-1:0] b_win;

  for (genvar j = 0; j < N; j++) begin : g_rev
    assign b_rev[j] = b[N-1-j];
  end

  // Zero padding on both sides lets each coefficient pick a fixed window
  assign b_win = {{(N-1){1'b0}}, b_rev, {(N-1){1'b0}}};

  // Coefficient k: XOR of a[i] & b[k-i]; window bit i is b[k-i] or zero
  for (genvar k = 0; k < PW; k++) begin : g_coef
    assign prod[k] = ^(a & b_win[2*N-2-k +: N]);
  end
endmodule

// File: rtl/gf2m_trinom_reduce.sv
// Two-pass fold of a (2N-1)-bit product modulo x^N + x^T + 1.
module gf2m_trinom_reduce #(
  parameter int unsigned N = 233,
  parameter int unsigned T = 74
) (
  input  logic [2*N-2:0] prod,
  output logic [N-1:0]   res
);
  // After pass one the highest set degree is (N-2)+T
  localparam int unsigned W1 = N - 1 + T;

  logic [W1-1:0] lo_ext;
  logic [W1-1:0] hi_ext;
  logic [W1-1:0] pass1;
  logic [N-1:0]  hi2_ext;

  always_comb begin
    lo_ext  = W1'(prod[N-1:0]);
    hi_ext  = W1'(prod[2*N-2:N]);
    // x^(N+m) = x^m + x^(m+T)
    pass1   = lo_ext ^ hi_ext ^ (hi_ext << T);
    // Terms pushed past degree N-1 by the tap fold once more
    hi2_ext = N'(pass1[W1-1:N]);
    res     = pass1[N-1:0] ^ hi2_ext ^ (hi2_ext << T);
  end

  always_comb begin
    // R6
    if (~|prod[2*N-2:N]) begin
      low_pass_chk : assert (res == prod[N-1:0]);
    end
    // R4
    zero_map_chk : assert ((|prod) || (~|res));
  end
endmodule

// File: rtl/gf233_mul.sv
module gf233_mul
  import gf2m_pkg::*;
#(
  parameter int unsigned N = GF_WIDTH,
  parameter int unsigned T = GF_TAP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_start,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  output logic [N-1:0] out_result
);
  localparam int unsigned PW = 2*N - 1;

  // Stage 1: captured operands
  logic         s1_vld_q, s1_vld_d;
  logic [N-1:0] s1_a_q, s1_b_q;
  // Stage 2: unreduced product
  logic         s2_vld_q, s2_vld_d;
  logic [PW-1:0] s2_prod_q, prod_w;
  // Stage 3: reduced result
  logic         s3_vld_q, s3_vld_d;
  logic [N-1:0] s3_res_q, res_w;

  gf2m_clmul #(.N(N)) u_clmul (
    .a    (s1_a_q),
    .b    (s1_b_q),
    .prod (prod_w)
  );

  gf2m_trinom_reduce #(.N(N), .T(T)) u_reduce (
    .prod (s2_prod_q),
    .res  (res_w)
  );

  always_comb begin
    s1_vld_d = in_start;
    s2_vld_d = s1_vld_q;
    s3_vld_d = s2_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      s3_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s2_vld_q <= s2_vld_d;
      s3_vld_q <= s3_vld_d;
    end
  end

  // Data registers: no reset, loaded only when their stage carries a pair
  always_ff @(posedge clk) begin
    if (in_start) begin
      s1_a_q <= in_a;
      s1_b_q <= in_b;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_vld_q) begin
      s2_prod_q <= prod_w;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_vld_q) begin
      s3_res_q <= res_w;
    end
  end

  assign out_valid  = s3_vld_q;
  assign out_result = s3_res_q;

  // R2
  start_cap_chk : assert property (@(posedge clk) disable iff (!rst_n)
    in_start |=> s1_vld_q);
  // R2
  s1_adv_chk : assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_q |=> s2_vld_q);
  // R3
  s2_out_chk : assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld_q |=> out_valid);
  // R9
  idle_out_chk : assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld_q |=> !out_valid);
  // R7
  hold_res_chk : assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld_q |=> $stable(out_result));
endmodule

// File: tb/tb_gf233_mul.sv
`timescale 1ns/1ps
module tb_gf233_mul;
  localparam int unsigned N = 233;
  localparam int unsigned T = 74;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_start;
  logic [N-1:0] in_a, in_b;
  logic         out_valid;
  logic [N-1:0] out_result;

  int total = 0;
  int fails = 0;

  logic [N-1:0] sa [0:7];
  logic [N-1:0] sb [0:7];

  always #10 clk = ~clk;

  gf233_mul #(.N(N), .T(T)) dut (
    .clk(clk), .rst_n(rst_n), .in_start(in_start),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result)
  );

  // Bit-serial shift-and-add multiply, reducing after each shift
  function automatic logic [N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
    logic [N-1:0] r = '0;
    for (int i = N-1; i >= 0; i--) begin
      logic top = r[N-1];
      r = r << 1;
      if (top) begin
        r[T] = ~r[T];
        r[0] = ~r[0];
      end
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] rnd();
    logic [N-1:0] v = '0;
    for (int w = 0; w < (N+31)/32; w++) v = (v << 32) | N'($urandom());
    return v;
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: out_valid got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: result got %h expected %h", req, act, exp);
    end
  endtask

  // Drives n pairs back to back, checks each result three edges later
  task automatic stream(int n, string req);
    for (int t = 0; t < n + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        check_bit(req, out_valid, 1'b1);
        check_vec(req, out_result, ref_mul(sa[t-3], sb[t-3]));
      end else begin
        check_bit(req, out_valid, 1'b0);
      end
      if (t < n) begin
        in_start = 1'b1; in_a = sa[t]; in_b = sb[t];
      end else begin
        in_start = 1'b0;
      end
    end
    @(negedge clk);
    check_bit(req, out_valid, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_start = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    check_bit("R8 reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_zero();
    sa[0] = '0;    sb[0] = rnd();
    sa[1] = rnd(); sb[1] = '0;
    stream(2, "R4 zero");
    check_vec("R4 zero", out_result, '0);
  endtask

  task automatic t_one();
    logic [N-1:0] x = rnd();
    sa[0] = x; sb[0] = N'(1);
    stream(1, "R5 one");
    check_vec("R5 one", out_result, x);
    sa[0] = N'(1); sb[0] = x;
    stream(1, "R5 one");
    check_vec("R5 one", out_result, x);
  endtask

  task automatic t_wrap();
    logic [N-1:0] e = '0;
    sa[0] = '0; sa[0][N-1] = 1'b1; sb[0] = N'(2);
    stream(1, "R6 wrap");
    e[T] = 1'b1; e[0] = 1'b1;
    check_vec("R6 wrap", out_result, e);
    sb[0] = sa[0];
    stream(1, "R6 double fold");
    e = '0; e[231] = 1'b1; e[146] = 1'b1; e[72] = 1'b1;
    check_vec("R6 double fold", out_result, e);
  endtask

  task automatic t_random();
    for (int k = 0; k < 8; k++) begin
      sa[k] = rnd(); sb[k] = rnd();
    end
    stream(8, "R1 R3 random");
    for (int k = 0; k < 8; k++) begin
      sa[k] = rnd() | {1'b1, {(N-1){1'b0}}}; sb[k] = ~rnd();
    end
    stream(8, "R1 R2 dense");
  endtask

  task automatic t_idle();
    logic [N-1:0] last = out_result;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_bit("R9 idle", out_valid, 1'b0);
      check_vec("R7 hold", out_result, last);
      in_start = 1'b0; in_a = rnd(); in_b = rnd();
    end
  endtask

  task automatic t_reset_flight();
    @(negedge clk);
    in_start = 1'b1; in_a = rnd(); in_b = rnd();
    @(negedge clk);
    in_start = 1'b0; rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_bit("R8 flight", out_valid, 1'b0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check_bit("R8 flight", out_valid, 1'b0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_one();
    t_wrap();
    t_random();
    t_idle();
    t_reset_flight();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule